// File: doc/BRIEF.md
# Two-Stage Overcurrent Fault Qualifier

This block protects an inductive load by deciding, in hardware, whether a high-current event is a real fault or switching noise. It watches two digital comparator outputs: a pre-warning comparator that goes high when load current passes a lower reference, and a trip comparator that goes high at the shutdown level. A pre-warning opens a confirmation window of programmable length. During the window the trip comparator is not acted on. When the window closes, the trip comparator is sampled once. If it is still high, the drive enable is removed and a fault is latched. If it is low, the load keeps running.

The window is set a little longer than the expected noise burst, for example about 100 ns, converted to clock cycles by the integrator. A latched fault stays in place until software or a supervisor pulses the clear input while the trip comparator reads low.

Top module: `ocp_trip_qualifier`

## Requirements
- R1: After reset, `drive_en_o` is 1, `fault_o` is 0 and `armed_o` is 0.
- R2: Both comparator inputs pass through a two-flop synchronizer. A high level on `warn_cmp_i` that is present at one rising edge, even for a single cycle, makes `armed_o` go to 1 after the third rising edge counted from that edge.
- R3: The trip comparator alone, with the pre-warning comparator low, never causes a shutdown or arms the window.
- R4: Trip comparator activity that starts and ends inside the window causes no shutdown. Only its synchronized level at the end of the window counts.
- R5: The window lasts `confirm_cycles_i + 1` cycles of `armed_o` high. If the synchronized trip level is high at the final cycle, the next edge sets `fault_o` to 1, clears `drive_en_o` and drops `armed_o`. With a delay value of N this is N+4 edges after the pre-warning was first sampled.
- R6: If the trip level is low at the end of the window, `drive_en_o` stays 1, `fault_o` stays 0 and `armed_o` drops. The block re-arms if the pre-warning is still high.
- R7: Once set, `fault_o` stays 1 and `drive_en_o` stays 0 regardless of either comparator, until a valid clear.
- R8: A one-cycle `clear_i` releases the fault at the next edge only when the synchronized trip level is low. A clear while the trip level is high is ignored.
- R9: A new pre-warning during an open window does not restart the timer. The delay value is captured when the window opens, so later changes do not affect the current window.
- R10: A delay value of 0 samples the trip level on the cycle right after the window opens. In that case the fault appears 4 edges after the pre-warning was first sampled.
- R11: `drive_en_o` is always the inverse of `fault_o`, and `armed_o` and `fault_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| warn_cmp_i | input | 1 | Pre-warning comparator, asynchronous |
| trip_cmp_i | input | 1 | Trip-level comparator, asynchronous |
| confirm_cycles_i | input | 16 | Window length minus one, in clock cycles |
| clear_i | input | 1 | Fault release strobe, synchronous |
| drive_en_o | output | 1 | Load drive enable, 0 while faulted |
| fault_o | output | 1 | Latched shutdown flag |
| armed_o | output | 1 | Confirmation window open |

## Verification
A timer that loads the wrong value or reloads on a second pre-warning shows up at the ports as a fault edge that arrives early or late against the N+4 edge count. The bench checks it on the exact edge, one cycle before and at the expected cycle. A trip level sampled at the wrong moment shows as a spurious fault right after a filtered pulse, or as a missing fault within one cycle of the window's end. A fault latch that leaks or clears too easily shows as `drive_en_o` returning high while the comparators are quiet or while the trip level is high. This is checked within one cycle of the clear.

// File: rtl/ocpq_pkg.sv
// Package: shared widths and types for the overcurrent fault qualifier.
// Assumes: a 16-bit delay field is enough for the target clock rates.
package ocpq_pkg;
    parameter int unsigned OCPQ_CNT_W       = 16;
    parameter int unsigned OCPQ_SYNC_STAGES = 2;
    typedef logic [OCPQ_CNT_W-1:0] ocpq_cnt_t;
endpackage

// File: rtl/ocpq_sync.sv
// Module: multi-bit level synchronizer, one independent flop chain per bit.
// Assumes: inputs are slow levels; bits are not required to stay coherent
// with each other. STAGES must be at least 2.
module ocpq_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;

            // Shift the raw input through the flop chain for this bit.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            end

            assign sync_o[b] = chain_q[LAST];
        end
    endgenerate
endmodule

// File: rtl/ocpq_confirm_timer.sv
// Module: confirmation window timer. Opens on a synchronized pre-warning,
// counts down the captured delay and flags a confirmed trip at expiry.
// Assumes: inputs are already synchronized; `hold_i` (latched fault)
// blocks opening a new window.
module ocpq_confirm_timer
    import ocpq_pkg::*;
#(
    parameter int unsigned CNT_W = OCPQ_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warn_s_i,
    input  logic             trip_s_i,
    input  logic             hold_i,
    input  logic [CNT_W-1:0] delay_i,
    output logic             armed_o,
    output logic             confirm_o
);
    logic             armed_q;
    logic [CNT_W-1:0] left_q;
    logic             expiring;

    assign expiring  = armed_q && (left_q == '0);
    assign confirm_o = expiring && trip_s_i;
    assign armed_o   = armed_q;

    // Open the window on a pre-warning, count down, close on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            left_q  <= '0;
        end else if (armed_q) begin
            if (expiring) armed_q <= 1'b0;
            else          left_q  <= left_q - 1'b1;
        end else if (warn_s_i && !hold_i) begin
            armed_q <= 1'b1;
            left_q  <= delay_i;
        end
    end

    // R5: window stays open while count remains
    armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && left_q != '0) |=> armed_q);

    // R9: a pending count never grows while the window is open
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(armed_q)) |-> (left_q < $past(left_q)) || (left_q == $past(left_q) && left_q == '0));

    // R10: window closes the cycle after it sees a zero count
    zero_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && left_q == '0) |=> !armed_q);
endmodule

// File: rtl/ocpq_fault_latch.sv
// Module: shutdown latch. Sets on a confirmed trip, releases on a clear
// strobe only while the synchronized trip level is low.
// Assumes: `set_i` is a single-cycle pulse from the timer.
module ocpq_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clear_i,
    input  logic trip_s_i,
    output logic fault_o,
    output logic drive_en_o
);
    logic fault_q;
    logic drive_q;

    // Hold the fault until a clear arrives with the trip level low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
            drive_q <= 1'b1;
        end else if (set_i) begin
            fault_q <= 1'b1;
            drive_q <= 1'b0;
        end else if (fault_q && clear_i && !trip_s_i) begin
            fault_q <= 1'b0;
            drive_q <= 1'b1;
        end
    end

    assign fault_o    = fault_q;
    assign drive_en_o = drive_q;

    // R7: fault persists without a clear
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !clear_i) |=> fault_q);

    // R8: clear while trip is high does not release
    clear_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && trip_s_i) |=> fault_q);

    // R11: drive enable is the complement of the fault
    drive_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_q == !fault_q);
endmodule

// File: rtl/ocp_trip_qualifier.sv
// Module: top of the two-stage overcurrent fault qualifier.
// Synchronizes both comparators, runs the confirmation window and latches
// the shutdown. Assumes confirm_cycles_i is quasi-static around arming.
module ocp_trip_qualifier
    import ocpq_pkg::*;
#(
    parameter int unsigned CNT_W       = OCPQ_CNT_W,
    parameter int unsigned SYNC_STAGES = OCPQ_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warn_cmp_i,
    input  logic             trip_cmp_i,
    input  logic [CNT_W-1:0] confirm_cycles_i,
    input  logic             clear_i,
    output logic             drive_en_o,
    output logic             fault_o,
    output logic             armed_o
);
    localparam int unsigned IDX_WARN = 0;
    localparam int unsigned IDX_TRIP = 1;
    localparam int unsigned N_CMP    = 2;

    logic [N_CMP-1:0] cmp_raw;
    logic [N_CMP-1:0] cmp_s;
    logic             confirm;
    logic             fault_int;

    assign cmp_raw[IDX_WARN] = warn_cmp_i;
    assign cmp_raw[IDX_TRIP] = trip_cmp_i;

    ocpq_sync #(.W(N_CMP), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_raw),
        .sync_o  (cmp_s)
    );

    ocpq_confirm_timer #(.CNT_W(CNT_W)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .warn_s_i  (cmp_s[IDX_WARN]),
        .trip_s_i  (cmp_s[IDX_TRIP]),
        .hold_i    (fault_int),
        .delay_i   (confirm_cycles_i),
        .armed_o   (armed_o),
        .confirm_o (confirm)
    );

    ocpq_fault_latch latch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (confirm),
        .clear_i    (clear_i),
        .trip_s_i   (cmp_s[IDX_TRIP]),
        .fault_o    (fault_int),
        .drive_en_o (drive_en_o)
    );

    assign fault_o = fault_int;

    // R11: window and fault are exclusive
    armed_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed_o && fault_o));

    // R5: a fault only begins at the close of a window
    fault_from_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> $past(armed_o));

    // R3: without an open window the trip level cannot raise a fault
    no_direct_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_o && !fault_o) |=> !fault_o);
endmodule

// File: tb/ocp_trip_qualifier_tb_top.sv
// Directed bench: inputs change and outputs are sampled 2 ns after each edge.
module ocp_trip_qualifier_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warn = 1'b0;
    logic        trip = 1'b0;
    logic [15:0] dly = 16'd0;
    logic        clr = 1'b0;
    logic        drive_en, fault, armed;
    int          n_run = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    ocp_trip_qualifier dut_i (
        .clk(clk), .rst_n(rst_n), .warn_cmp_i(warn), .trip_cmp_i(trip),
        .confirm_cycles_i(dly), .clear_i(clr),
        .drive_en_o(drive_en), .fault_o(fault), .armed_o(armed)
    );

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; warn = 0; trip = 0; clr = 0; dly = 0;
        step(3);
        rst_n = 1'b1;
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        chk("R1", "drive_en", drive_en, 1);
        chk("R1", "fault", fault, 0);
        chk("R1", "armed", armed, 0);
    endtask

    // R3: trip alone
    task automatic t_trip_alone();
        do_reset();
        trip = 1; dly = 3;
        step(20);
        chk("R3", "fault", fault, 0);
        chk("R3", "armed", armed, 0);
        chk("R3", "drive_en", drive_en, 1);
    endtask

    // R2, R5: single-cycle warn, trip held, N=5
    task automatic t_confirmed();
        do_reset();
        dly = 5; trip = 1; warn = 1;
        step(1); warn = 0;
        step(1);
        chk("R2", "armed before 3rd edge", armed, 0);
        step(1);
        chk("R2", "armed at 3rd edge", armed, 1);
        step(5);
        chk("R5", "fault one edge early", fault, 0);
        chk("R5", "armed on last window cycle", armed, 1);
        step(1);
        chk("R5", "fault at N+4", fault, 1);
        chk("R5", "drive_en at N+4", drive_en, 0);
        chk("R5", "armed closed", armed, 0);
    endtask

    // R4, R6: trip pulse inside window, low at expiry
    task automatic t_filtered();
        do_reset();
        dly = 10; warn = 1;
        step(1); warn = 0;
        step(2);
        trip = 1;
        step(2);
        trip = 0;
        step(9);
        chk("R6", "armed dropped at expiry", armed, 0);
        chk("R4", "fault after filtered pulse", fault, 0);
        step(5);
        chk("R6", "drive_en kept", drive_en, 1);
        chk("R4", "fault later", fault, 0);
    endtask

    // R6: warn held keeps re-arming
    task automatic t_rearm();
        do_reset();
        dly = 2; warn = 1;
        step(3 + 3);
        chk("R6", "armed closes", armed, 0);
        step(1);
        chk("R6", "re-armed", armed, 1);
        warn = 0;
        step(4);
        chk("R6", "drive_en", drive_en, 1);
    endtask

    // R9: second warn and delay change do not restart
    task automatic t_no_restart();
        do_reset();
        dly = 6; trip = 1; warn = 1;
        step(1); warn = 0;
        step(3);
        warn = 1; dly = 0;
        step(1); warn = 0; dly = 40;
        step(4);
        chk("R9", "fault one edge early", fault, 0);
        step(1);
        chk("R9", "fault at original N+4", fault, 1);
    endtask

    // R10: zero delay
    task automatic t_zero();
        do_reset();
        dly = 0; trip = 1; warn = 1;
        step(1); warn = 0;
        step(2);
        chk("R10", "armed", armed, 1);
        chk("R10", "fault not yet", fault, 0);
        step(1);
        chk("R10", "fault at 4th edge", fault, 1);
    endtask

    // R7, R8, R11: latch and clear rules
    task automatic t_latch_clear();
        do_reset();
        dly = 1; trip = 1; warn = 1;
        step(1); warn = 0;
        step(5);
        chk("R7", "fault set", fault, 1);
        clr = 1; step(1); clr = 0;
        chk("R8", "clear with trip high", fault, 1);
        trip = 0;
        step(20);
        chk("R7", "fault held quiet", fault, 1);
        chk("R11", "drive_en while faulted", drive_en, 0);
        chk("R11", "armed while faulted", armed, 0);
        clr = 1; step(1); clr = 0;
        chk("R8", "fault cleared", fault, 0);
        chk("R8", "drive_en restored", drive_en, 1);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_trip_alone();
        t_confirmed();
        t_filtered();
        t_rearm();
        t_no_restart();
        t_zero();
        t_latch_clear();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule